// File: doc/BRIEF.md
# Timer Output Set/Clear Controller

This block holds the state of sixteen timer output pins. Each pin is updated from a pair of event request lines, one to set the pin and one to clear it. A per-output direction-control field can make set and clear trade places while a chosen counter is counting down. With this, a pin can rise on a match while the counter counts up and fall on the same match while it counts down, which gives centre-aligned waveforms.

Software reaches the block through a small register port with two registers. One register holds the output states. Software can read it at any time, but a write to it is accepted only while both the low and the high counter are halted. A write attempted while either counter runs changes nothing and gets an error response. The other register holds the sixteen two-bit direction fields and accepts writes at any time.

Top module: `tmr_out_ctrl`

## Requirements
- R1: After reset all sixteen outputs are 0 and every direction field is 0.
- R2: A write (`reg_req_i`=1, `reg_we_i`=1, `reg_sel_i`=0) while `lo_halt_i`=1 and `hi_halt_i`=1 loads `reg_wdata_i[n]` into output n at the next clock edge. `reg_err_o` stays 0 for that write.
- R3: A write with `reg_sel_i`=0 while `lo_halt_i`=0 or `hi_halt_i`=0 raises `reg_err_o` in the same cycle and leaves the outputs unchanged.
- R4: With `reg_sel_i`=0, `reg_rdata_o[15:0]` shows the current outputs (output n on bit n) and bits 31:16 read 0. This holds whether or not the counters are halted.
- R5: A write with `reg_sel_i`=1 is always accepted without an error and loads the direction register at the next edge. With `reg_sel_i`=1, `reg_rdata_o` returns that register. The field for output n sits at bits 2n+1:2n.
- R6: For each output, with effective requests: set alone drives it to 1, clear alone drives it to 0, and neither holds it. Set and clear together toggle it. The change appears at the next clock edge.
- R7: Field value 0 never swaps set and clear.
- R8: Field value 1 swaps set and clear while `lo_down_i`=1. The low counter stands for the unified counter when `unify_i`=1.
- R9: Field value 2 swaps set and clear while `hi_down_i`=1 and `unify_i`=0. While `unify_i`=1 it behaves as value 0.
- R10: Field value 3 behaves as value 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_req_i | input | 16 | Per-output set requests |
| clr_req_i | input | 16 | Per-output clear requests |
| lo_halt_i | input | 1 | Low counter is halted |
| hi_halt_i | input | 1 | High counter is halted |
| lo_down_i | input | 1 | Low (or unified) counter counts down |
| hi_down_i | input | 1 | High counter counts down |
| unify_i | input | 1 | Both halves operate as a single counter |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Access is a write |
| reg_sel_i | input | 1 | Register select: 0 = outputs, 1 = direction fields |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| reg_err_o | output | 1 | Error response to a rejected output write |
| pins_o | output | 16 | Output pin states |

## Verification
The bench tries output writes with exactly one counter running. A design that checks only one halt flag would load the pins there, or would fail to flag the error. It drives set and clear together on every mode. A design that gives one request priority instead of toggling would leave the pin at a fixed level. It sweeps field value 2 with the unify flag on and off, and field value 3 with both down flags high. Decoding that swaps on the wrong counter, or that treats the reserved value as active, would invert pins the model expects to keep their polarity. A long random phase also mixes direction-register writes with events in the same cycle, so a design that applies a new field value one cycle early would be caught.

// File: rtl/tmr_out_pkg.sv
package tmr_out_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    DIR_NONE = 2'd0,
    DIR_LO   = 2'd1,
    DIR_HI   = 2'd2,
    DIR_RSVD = 2'd3
  } dir_mode_e;

  localparam logic SEL_OUT = 1'b0;
  localparam logic SEL_DIR = 1'b1;
endpackage

// File: rtl/tmr_out_regif.sv
module tmr_out_regif
  import tmr_out_pkg::*;
#(
  parameter int unsigned N_OUT  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned DIR_W = N_OUT * MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lo_halt_i,
  input  logic              hi_halt_i,
  input  logic [N_OUT-1:0]  pins_i,
  output logic              out_wr_o,
  output logic [DIR_W-1:0]  dir_q_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  logic wr_out, wr_dir, all_halt;

  assign all_halt = lo_halt_i & hi_halt_i;
  assign wr_out   = req_i & we_i & (sel_i == SEL_OUT);
  assign wr_dir   = req_i & we_i & (sel_i == SEL_DIR);
  assign out_wr_o = wr_out & all_halt;
  assign err_o    = wr_out & ~all_halt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_q_o <= '0;
    else if (wr_dir) dir_q_o <= wdata_i[DIR_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i == SEL_DIR) rdata_o[DIR_W-1:0] = dir_q_o;
    else                  rdata_o[N_OUT-1:0] = pins_i;
  end

  AST_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_wr_o && err_o)); // R3
  AST_DIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir |=> dir_q_o == $past(wdata_i[DIR_W-1:0])); // R5
  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir |=> $stable(dir_q_o)); // R5
endmodule

// File: rtl/tmr_out_polarity.sv
module tmr_out_polarity
  import tmr_out_pkg::*;
#(
  parameter int unsigned N_OUT = 16,
  localparam int unsigned DIR_W = N_OUT * MODE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIR_W-1:0] dir_q_i,
  input  logic [N_OUT-1:0] set_i,
  input  logic [N_OUT-1:0] clr_i,
  input  logic             lo_down_i,
  input  logic             hi_down_i,
  input  logic             unify_i,
  output logic [N_OUT-1:0] eff_set_o,
  output logic [N_OUT-1:0] eff_clr_o
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    dir_mode_e mode;
    logic      swap;
    assign mode = dir_mode_e'(dir_q_i[g*MODE_W +: MODE_W]);
    // reserved code and high-counter code under unify fall back to no swap
    assign swap = ((mode == DIR_LO) && lo_down_i) ||
                  ((mode == DIR_HI) && !unify_i && hi_down_i);
    assign eff_set_o[g] = swap ? clr_i[g] : set_i[g];
    assign eff_clr_o[g] = swap ? set_i[g] : clr_i[g];

    AST_RSVD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == DIR_RSVD) |-> (eff_set_o[g] == set_i[g] && eff_clr_o[g] == clr_i[g])); // R10
    AST_HI_UNIFY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == DIR_HI && unify_i) |-> (eff_set_o[g] == set_i[g])); // R9
    AST_NONE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == DIR_NONE) |-> (eff_clr_o[g] == clr_i[g])); // R7
  end
endmodule

// File: rtl/tmr_out_cell.sv
module tmr_out_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ld_i,
  input  logic ld_val_i,
  output logic q_o
);
  logic q_nxt;

  always_comb begin
    unique case ({set_i, clr_i})
      2'b11:   q_nxt = ~q_o;
      2'b10:   q_nxt = 1'b1;
      2'b01:   q_nxt = 1'b0;
      default: q_nxt = q_o;
    endcase
    if (ld_i) q_nxt = ld_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_nxt;
  end

  AST_BOTH_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i && !ld_i) |=> q_o != $past(q_o)); // R6
  AST_SW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> q_o == $past(ld_val_i)); // R2
endmodule

// File: rtl/tmr_out_ctrl.sv
module tmr_out_ctrl
  import tmr_out_pkg::*;
#(
  parameter int unsigned N_OUT  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_OUT-1:0]  set_req_i,
  input  logic [N_OUT-1:0]  clr_req_i,
  input  logic              lo_halt_i,
  input  logic              hi_halt_i,
  input  logic              lo_down_i,
  input  logic              hi_down_i,
  input  logic              unify_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_err_o,
  output logic [N_OUT-1:0]  pins_o
);
  localparam int unsigned DIR_W = N_OUT * MODE_W;

  logic             out_wr;
  logic [DIR_W-1:0] dir_q;
  logic [N_OUT-1:0] eff_set, eff_clr;

  tmr_out_regif #(.N_OUT(N_OUT), .DATA_W(DATA_W)) u_regif (
    .clk_i, .rst_ni,
    .req_i     (reg_req_i),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .lo_halt_i,
    .hi_halt_i,
    .pins_i    (pins_o),
    .out_wr_o  (out_wr),
    .dir_q_o   (dir_q),
    .rdata_o   (reg_rdata_o),
    .err_o     (reg_err_o)
  );

  tmr_out_polarity #(.N_OUT(N_OUT)) u_pol (
    .clk_i, .rst_ni,
    .dir_q_i   (dir_q),
    .set_i     (set_req_i),
    .clr_i     (clr_req_i),
    .lo_down_i,
    .hi_down_i,
    .unify_i,
    .eff_set_o (eff_set),
    .eff_clr_o (eff_clr)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_cell
    tmr_out_cell u_cell (
      .clk_i, .rst_ni,
      .set_i    (eff_set[g]),
      .clr_i    (eff_clr[g]),
      .ld_i     (out_wr),
      .ld_val_i (reg_wdata_i[g]),
      .q_o      (pins_o[g])
    );
  end

  AST_REJECT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_err_o && set_req_i == '0 && clr_req_i == '0) |=> $stable(pins_o)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_req_i && set_req_i == '0 && clr_req_i == '0) |=> $stable(pins_o)); // R6
endmodule

// File: tb/tmr_out_ctrl_bench.sv
module tmr_out_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] set_req = '0, clr_req = '0;
  logic        lo_halt = 1'b1, hi_halt = 1'b1, lo_down = 1'b0, hi_down = 1'b0, unify = 1'b0;
  logic        req = 1'b0, we = 1'b0, sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [15:0] pins;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_pins;
  logic [31:0] m_dir;

  always #2.5 clk = ~clk;

  tmr_out_ctrl u_tmr_out_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .set_req_i(set_req), .clr_req_i(clr_req),
    .lo_halt_i(lo_halt), .hi_halt_i(hi_halt), .lo_down_i(lo_down), .hi_down_i(hi_down),
    .unify_i(unify), .reg_req_i(req), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_err_o(err), .pins_o(pins)
  );

  // behavioural reference, updated on every edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pins = '0;
      m_dir  = '0;
    end else begin
      logic [15:0] nxt;
      nxt = m_pins;
      for (int n = 0; n < 16; n++) begin
        int  md;
        bit  s, c, sw;
        md = (m_dir >> (2*n)) & 3;
        sw = (md == 1 && lo_down) || (md == 2 && !unify && hi_down);
        s  = sw ? clr_req[n] : set_req[n];
        c  = sw ? set_req[n] : clr_req[n];
        if (s && c) nxt[n] = ~m_pins[n];
        else if (s) nxt[n] = 1'b1;
        else if (c) nxt[n] = 1'b0;
      end
      if (req && we && !sel && lo_halt && hi_halt) nxt = wdata[15:0];
      if (req && we && sel) m_dir = wdata;
      m_pins = nxt;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge: drive, check combinational replies, clock, check pins
  task automatic step(input string tag, input logic r, input logic w, input logic s,
                      input logic [31:0] d, input logic [15:0] st, input logic [15:0] cl,
                      input logic lh, input logic hh, input logic ld, input logic hd,
                      input logic un);
    logic e_err;
    req = r; we = w; sel = s; wdata = d; set_req = st; clr_req = cl;
    lo_halt = lh; hi_halt = hh; lo_down = ld; hi_down = hd; unify = un;
    #1;
    e_err = r && w && !s && !(lh && hh);
    chk("R3 err", {31'b0, err}, {31'b0, e_err});
    if (s) chk("R5 rdata", rdata, m_dir);
    else   chk("R4 rdata", rdata, {16'b0, m_pins});
    @(posedge clk);
    @(negedge clk);
    chk(tag, {16'b0, pins}, {16'b0, m_pins});
  endtask

  task automatic ev(input string tag, input logic [15:0] st, input logic [15:0] cl,
                    input logic ld, input logic hd, input logic un);
    step(tag, 0, 0, 0, 0, st, cl, 0, 0, ld, hd, un);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pins", {16'b0, pins}, 32'h0);
    sel = 1'b1; #1;
    chk("R1 dir", rdata, 32'h0);
    sel = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pins after release", {16'b0, pins}, 32'h0);

    // R5 direction register
    step("R5 dir write", 1, 1, 1, 32'h1B2D_3C4E, 0, 0, 0, 0, 0, 0, 0);
    step("R5 dir read",  1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R5 dir write running", 1, 1, 1, 32'h0, 0, 0, 0, 0, 0, 0, 0);
    step("R5 dir read zero", 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);

    // R2 accepted writes
    step("R2 write A5C3", 1, 1, 0, 32'hFFFF_A5C3, 0, 0, 1, 1, 0, 0, 0);
    step("R2 write 5A3C", 1, 1, 0, 32'h0000_5A3C, 0, 0, 1, 1, 0, 0, 0);
    step("R4 read halted", 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);

    // R3 rejected writes
    step("R3 lo running", 1, 1, 0, 32'h0000_FFFF, 0, 0, 0, 1, 0, 0, 0);
    step("R3 hi running", 1, 1, 0, 32'h0000_0000, 0, 0, 1, 0, 0, 0, 0);
    step("R3 both running", 1, 1, 0, 32'h0000_1234, 0, 0, 0, 0, 0, 0, 0);
    step("R4 read running", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R6 basic event handling, mode 0
    ev("R6 set", 16'h00F0, 16'h0000, 0, 0, 0);
    ev("R6 clr", 16'h0000, 16'h0F0F, 0, 0, 0);
    ev("R6 hold", 16'h0000, 16'h0000, 0, 0, 0);
    ev("R6 toggle", 16'hFFFF, 16'hFFFF, 0, 0, 0);
    ev("R6 toggle again", 16'hFFFF, 16'hFFFF, 0, 0, 0);
    ev("R6 mix", 16'h1234, 16'h4321, 0, 0, 0);

    // R7 mode 0 ignores direction
    ev("R7 lo down", 16'h00FF, 16'hFF00, 1, 1, 0);
    ev("R7 hi down", 16'hFF00, 16'h00FF, 1, 1, 1);

    // R8 mode 1
    step("R8 dir", 1, 1, 1, 32'h5555_5555, 0, 0, 0, 0, 0, 0, 0);
    ev("R8 up", 16'h00FF, 16'hFF00, 0, 1, 0);
    ev("R8 down", 16'h00FF, 16'hFF00, 1, 0, 0);
    ev("R8 down unified", 16'h0F0F, 16'hF0F0, 1, 0, 1);
    ev("R8 down both", 16'hFFFF, 16'h0000, 1, 1, 0);

    // R9 mode 2
    step("R9 dir", 1, 1, 1, 32'hAAAA_AAAA, 0, 0, 0, 0, 0, 0, 0);
    ev("R9 hi down", 16'h00FF, 16'hFF00, 0, 1, 0);
    ev("R9 lo down only", 16'hFF00, 16'h00FF, 1, 0, 0);
    ev("R9 hi down unified", 16'h00FF, 16'hFF00, 0, 1, 1);
    ev("R9 hi down unified 2", 16'h0000, 16'hFFFF, 1, 1, 1);

    // R10 mode 3
    step("R10 dir", 1, 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0);
    ev("R10 both down", 16'h0FF0, 16'hF00F, 1, 1, 0);
    ev("R10 both down unified", 16'hF00F, 16'h0FF0, 1, 1, 1);

    // mixed per-output modes
    step("R8 mixed dir", 1, 1, 1, 32'hE4E4_1B1B, 0, 0, 0, 0, 0, 0, 0);
    ev("R9 mixed", 16'hAAAA, 16'h5555, 1, 1, 0);
    ev("R8 mixed", 16'h3C3C, 16'hC3C3, 1, 0, 1);

    // random mix including concurrent dir writes
    for (int i = 0; i < 600; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      step("R6 random", rv[0], rv[1], rv[2], $urandom, 16'($urandom), 16'($urandom),
           rv[3], rv[4], rv[5], rv[6], rv[7]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule